// File: doc/BRIEF.md
# Bidirectional Parity Transceiver

This block moves an 8-bit word between two bus ports, called A and B. A direction input picks the way the data flows, and an active-low enable can take the whole block off the bus. Parity is handled on the same path. When the block sends from A to B, it works out a parity bit from the A word and drives that bit onto a shared parity line. When it receives from B to A, the same line becomes an input. The block then checks the B word together with the received bit and drives an active-low error flag. A select input chooses between odd and even parity.

Every pin that would be tri-state on a real bus has three signals here: a value coming in, a value going out, and an output-enable. The surrounding pad logic combines them into the physical pin, so the block itself stays synthesizable. The block has no clock and no state, and its outputs follow its inputs directly. For this reason the house valid/ready streaming convention does not apply: there is no transfer to accept and no back-pressure. Every pin is plain, and a value counts as present only while its output-enable is high.

Top module: `ptx_transceiver`

## Requirements
- R1: With dir_i = 1 and oe_n_i = 0 (transmit), b_oe_o = 1, a_oe_o = 0 and b_out_o equals a_in_i bit for bit, with no inversion.
- R2: With dir_i = 0 and oe_n_i = 0 (receive), a_oe_o = 1, b_oe_o = 0 and a_out_o equals b_in_i bit for bit, with no inversion.
- R3: With oe_n_i = 1, a_oe_o, b_oe_o, par_oe_o and err_oe_o are all 0, whatever the other inputs are.
- R4: In transmit, par_oe_o = 1. With odd_sel_i = 0, par_out_o is 1 exactly when a_in_i has an odd number of ones. With odd_sel_i = 1, par_out_o is the inverse of that value.
- R5: In receive, par_oe_o = 0 and err_oe_o = 1. Let the total be the number of ones in b_in_i plus par_in_i. err_out_o is 1 (no error) when this total is even and odd_sel_i = 0, or when it is odd and odd_sel_i = 1. Otherwise err_out_o is 0.
- R6: In transmit, err_oe_o = 0.
- R7: Any data-out signal whose output-enable is 0 reads as all zeros. This covers a_out_o, b_out_o, par_out_o and err_out_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dir_i | input | 1 | 1 sends A to B, 0 sends B to A |
| oe_n_i | input | 1 | Active-low enable; 1 releases every driven pin |
| odd_sel_i | input | 1 | Parity sense: 0 even, 1 odd |
| a_in_i | input | WIDTH | Value seen on the A pins |
| a_out_o | output | WIDTH | Value to drive on the A pins |
| a_oe_o | output | 1 | Drive enable for the A pins |
| b_in_i | input | WIDTH | Value seen on the B pins |
| b_out_o | output | WIDTH | Value to drive on the B pins |
| b_oe_o | output | 1 | Drive enable for the B pins |
| par_in_i | input | 1 | Value seen on the parity line |
| par_out_o | output | 1 | Value to drive on the parity line |
| par_oe_o | output | 1 | Drive enable for the parity line |
| err_out_o | output | 1 | Active-low parity error flag |
| err_oe_o | output | 1 | Drive enable for the error flag |

## Verification
The stimulus covers every one of the 256 A words and every select setting, in all three modes, with both values of the received parity bit. This shows that each count of ones, odd or even, lands on the correct parity and error value, and that the received bit flips the error result.

The B word is a different permutation of the 256 values from the A word. A path that routed the wrong port therefore shows up as a data mismatch, and so does a path that inverted the data.

In the disabled mode the same sweep runs again with every input active. This shows that no enable and no stray data-out value leaks out of the block.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_TX  = 2'd1,
    MODE_RX  = 2'd2
  } ptx_mode_e;
endpackage

// File: rtl/ptx_route.sv
module ptx_route
  import ptx_pkg::*;
(
  input  logic      dir_i,
  input  logic      oe_n_i,
  output ptx_mode_e mode_o,
  output logic      a_oe_o,
  output logic      b_oe_o,
  output logic      par_oe_o,
  output logic      err_oe_o
);
  always_comb begin
    if (oe_n_i)     mode_o = MODE_OFF;
    else if (dir_i) mode_o = MODE_TX;
    else            mode_o = MODE_RX;
  end

  always_comb begin
    a_oe_o   = 1'b0;
    b_oe_o   = 1'b0;
    par_oe_o = 1'b0;
    err_oe_o = 1'b0;
    case (mode_o)
      MODE_TX: begin
        b_oe_o   = 1'b1;
        par_oe_o = 1'b1;
      end
      MODE_RX: begin
        a_oe_o   = 1'b1;
        err_oe_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ptx_parity_tree.sv
module ptx_parity_tree #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] data_i,
  output logic             odd_o
);
  localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 0;
  localparam int PADW   = 1 << LEVELS;
  localparam int NODES  = 2 * PADW - 1;

  // heap layout: leaves at PADW-1 .. NODES-1, root at 0
  logic [NODES-1:0] heap;

  genvar g;
  generate
    for (g = 0; g < PADW; g++) begin : g_leaf
      if (g < WIDTH) begin : g_used
        assign heap[PADW-1+g] = data_i[g];
      end else begin : g_pad
        assign heap[PADW-1+g] = 1'b0;
      end
    end
    for (g = 0; g < PADW - 1; g++) begin : g_node
      assign heap[g] = heap[2*g+1] ^ heap[2*g+2];
    end
  endgenerate

  assign odd_o = heap[0];
endmodule

// File: rtl/ptx_steer.sv
module ptx_steer
  import ptx_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  ptx_mode_e        mode_i,
  input  logic [WIDTH-1:0] a_in_i,
  input  logic [WIDTH-1:0] b_in_i,
  input  logic             a_odd_i,
  input  logic             b_odd_i,
  input  logic             odd_sel_i,
  input  logic             par_in_i,
  output logic [WIDTH-1:0] a_out_o,
  output logic [WIDTH-1:0] b_out_o,
  output logic             par_out_o,
  output logic             err_out_o
);
  always_comb begin
    a_out_o   = '0;
    b_out_o   = '0;
    par_out_o = 1'b0;
    err_out_o = 1'b0;
    case (mode_i)
      MODE_TX: begin
        b_out_o   = a_in_i;
        par_out_o = a_odd_i ^ odd_sel_i;
      end
      MODE_RX: begin
        a_out_o   = b_in_i;
        err_out_o = ~(b_odd_i ^ par_in_i ^ odd_sel_i);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ptx_transceiver.sv
module ptx_transceiver
  import ptx_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             dir_i,
  input  logic             oe_n_i,
  input  logic             odd_sel_i,
  input  logic [WIDTH-1:0] a_in_i,
  output logic [WIDTH-1:0] a_out_o,
  output logic             a_oe_o,
  input  logic [WIDTH-1:0] b_in_i,
  output logic [WIDTH-1:0] b_out_o,
  output logic             b_oe_o,
  input  logic             par_in_i,
  output logic             par_out_o,
  output logic             par_oe_o,
  output logic             err_out_o,
  output logic             err_oe_o
);
  ptx_mode_e mode;
  logic      a_odd;
  logic      b_odd;

  ptx_route u_route (
    .dir_i    (dir_i),
    .oe_n_i   (oe_n_i),
    .mode_o   (mode),
    .a_oe_o   (a_oe_o),
    .b_oe_o   (b_oe_o),
    .par_oe_o (par_oe_o),
    .err_oe_o (err_oe_o)
  );

  ptx_parity_tree #(.WIDTH(WIDTH)) u_tree_a (.data_i(a_in_i), .odd_o(a_odd));
  ptx_parity_tree #(.WIDTH(WIDTH)) u_tree_b (.data_i(b_in_i), .odd_o(b_odd));

  ptx_steer #(.WIDTH(WIDTH)) u_steer (
    .mode_i    (mode),
    .a_in_i    (a_in_i),
    .b_in_i    (b_in_i),
    .a_odd_i   (a_odd),
    .b_odd_i   (b_odd),
    .odd_sel_i (odd_sel_i),
    .par_in_i  (par_in_i),
    .a_out_o   (a_out_o),
    .b_out_o   (b_out_o),
    .par_out_o (par_out_o),
    .err_out_o (err_out_o)
  );

  always_comb begin
    p_single_driver_r1: assert (!(a_oe_o && b_oe_o));
    p_released_r3: assert (!oe_n_i || !(a_oe_o || b_oe_o || par_oe_o || err_oe_o));
    p_tx_word_sense_r4: assert (!par_oe_o || ((^{b_out_o, par_out_o}) == odd_sel_i));
    p_tx_err_float_r6: assert (!(par_oe_o && err_oe_o));
    p_quiet_b_r7: assert (b_oe_o || (b_out_o == '0));
    p_quiet_a_r7: assert (a_oe_o || (a_out_o == '0));
  end
endmodule

// File: tb/ptx_transceiver_bench.sv
module ptx_transceiver_bench;
  localparam int W = 8;

  typedef struct packed {
    logic [W-1:0] a_out;
    logic [W-1:0] b_out;
    logic a_oe, b_oe, par_out, par_oe, err_out, err_oe;
    logic idle, tx;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic dir, oe_n, osel, pin;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic a_oe, b_oe, par_out, par_oe, err_out, err_oe;

  ptx_transceiver #(.WIDTH(W)) u_ptx_transceiver (
    .dir_i(dir), .oe_n_i(oe_n), .odd_sel_i(osel),
    .a_in_i(a_in), .a_out_o(a_out), .a_oe_o(a_oe),
    .b_in_i(b_in), .b_out_o(b_out), .b_oe_o(b_oe),
    .par_in_i(pin), .par_out_o(par_out), .par_oe_o(par_oe),
    .err_out_o(err_out), .err_oe_o(err_oe)
  );

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(string tag, string what, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, got, exp);
    end
  endtask

  task automatic drive(logic d, logic oen, logic s, logic [W-1:0] a, logic [W-1:0] b, logic p);
    exp_t e;
    int ca, cb;
    logic tot;
    @(negedge clk);
    dir = d; oe_n = oen; osel = s; a_in = a; b_in = b; pin = p;
    ca = $countones(a);
    cb = $countones(b);
    tot = 1'((cb + int'(p)) % 2);
    e = '0;
    e.idle = oen;
    e.tx = d;
    if (!oen && d) begin
      e.b_oe = 1'b1; e.b_out = a; e.par_oe = 1'b1;
      e.par_out = 1'(ca % 2) ^ s;
    end
    if (!oen && !d) begin
      e.a_oe = 1'b1; e.a_out = b; e.err_oe = 1'b1;
      e.err_out = s ? tot : !tot;
    end
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    if (!rst && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      if (e.idle) begin
        chk("R3", "a_oe", W'(a_oe), W'(e.a_oe));
        chk("R3", "b_oe", W'(b_oe), W'(e.b_oe));
        chk("R3", "par_oe", W'(par_oe), W'(e.par_oe));
        chk("R3", "err_oe", W'(err_oe), W'(e.err_oe));
        chk("R7", "a_out", a_out, e.a_out);
        chk("R7", "b_out", b_out, e.b_out);
        chk("R7", "par_out", W'(par_out), W'(e.par_out));
        chk("R7", "err_out", W'(err_out), W'(e.err_out));
      end else if (e.tx) begin
        chk("R1", "b_oe", W'(b_oe), W'(e.b_oe));
        chk("R1", "a_oe", W'(a_oe), W'(e.a_oe));
        chk("R1", "b_out", b_out, e.b_out);
        chk("R4", "par_oe", W'(par_oe), W'(e.par_oe));
        chk("R4", "par_out", W'(par_out), W'(e.par_out));
        chk("R6", "err_oe", W'(err_oe), W'(e.err_oe));
        chk("R7", "a_out", a_out, e.a_out);
        chk("R7", "err_out", W'(err_out), W'(e.err_out));
      end else begin
        chk("R2", "a_oe", W'(a_oe), W'(e.a_oe));
        chk("R2", "b_oe", W'(b_oe), W'(e.b_oe));
        chk("R2", "a_out", a_out, e.a_out);
        chk("R5", "par_oe", W'(par_oe), W'(e.par_oe));
        chk("R5", "err_oe", W'(err_oe), W'(e.err_oe));
        chk("R5", "err_out", W'(err_out), W'(e.err_out));
        chk("R7", "b_out", b_out, e.b_out);
        chk("R7", "par_out", W'(par_out), W'(e.par_out));
      end
    end
  end

  initial begin
    dir = 1'b0; oe_n = 1'b1; osel = 1'b0; pin = 1'b0; a_in = '0; b_in = '0;
    repeat (4) @(posedge clk);
    rst = 1'b0;
    // first item: released state straight after reset (R3)
    drive(1'b0, 1'b1, 1'b0, '0, '0, 1'b0);
    for (int m = 0; m < 3; m++) begin
      for (int s = 0; s < 2; s++) begin
        for (int v = 0; v < 256; v++) begin
          for (int p = 0; p < 2; p++) begin
            logic [W-1:0] bv;
            bv = W'(v * 37 + 11);
            // m: 0 transmit, 1 receive, 2 released
            drive(m == 0 || (m == 2 && p == 1), m == 2, 1'(s), W'(v), bv, 1'(p));
          end
        end
      end
    end
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule